// File: doc/BRIEF.md
# Cascaded Second-Order IIR Filter

This block filters several channels of signed samples through a chain of second-order recursive sections. Every section evaluates a direct-form difference equation with five signed fixed-point coefficients. Each coefficient has two integer bits and COEF_W-2 fraction bits, so it spans [-2, 2). Both feedback coefficients are supplied already negated, so all five products are summed. The filter order is twice SECTIONS. All channels share one coefficient set, and each channel keeps its own history in every section.

Each section owns one multiplier per channel. It uses that multiplier once per clock over five clocks to build the sum. A section result is ready five clocks after the section takes its sample, and the section cannot start again until six clocks have passed. Sections hand results on through a valid/ready pair, so the cascade keeps a rate of one sample per six clocks for any number of sections.

The stream edges follow valid/ready handshake rules. The coefficients arrive as a flat vector held by an outside register file. When `filter_en` is low, the filter accepts nothing, drops any result in flight and zeroes every section's history.

Top module: `biquad_cascade`

## Requirements
- R1: Each section computes y[n] = b0·x[n] + b1·x[n-1] + b2·x[n-2] + c1·y[n-1] + c2·y[n-2], with c1 = -a1 and c2 = -a2. Section s, slot k, takes `coef_i[(s*5+k)*COEF_W +: COEF_W]`, with slots 0..4 holding b0, b1, b2, c1, c2. Section s+1 filters the output of section s, and `m_tdata` is the output of the last section.
- R2: The exact sum of the five products is scaled down by COEF_W-2 bits, rounding halves upward (floor of sum/2^F + 1/2). The result is then clamped to the signed DATA_W range.
- R3: With `m_tready` held high, an accepted input appears on `m_tvalid`/`m_tdata` 6·SECTIONS-1 clocks after the accepting edge.
- R4: Two input acceptances are never fewer than six clocks apart. With `s_tvalid` and `m_tready` held high, acceptances come exactly every six clocks.
- R5: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata` stays unchanged. Every accepted input produces exactly one output, in order.
- R6: Channel c occupies bits [c*DATA_W +: DATA_W] of both data buses. Each channel is filtered independently, so a channel with all-zero input gives all-zero output.
- R7: While `filter_en` is low, `s_tready` and `m_tvalid` are low from the next clock on, and no input is accepted. After `filter_en` rises, filtering restarts from zero history.
- R8: While `rst_n` is low, `s_tready` and `m_tvalid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_en | input | 1 | Run control; low clears all state and blocks input |
| coef_i | input | SECTIONS*5*COEF_W | Packed coefficients, five slots per section |
| s_tvalid | input | 1 | Input sample valid |
| s_tready | output | 1 | Filter can take an input sample |
| s_tdata | input | CHANNELS*DATA_W | Input samples, one lane per channel |
| m_tvalid | output | 1 | Output sample valid |
| m_tready | input | 1 | Downstream can take the output |
| m_tdata | output | CHANNELS*DATA_W | Filtered samples, one lane per channel |

## Verification
The hardest case to reach is a section that has finished its five products while the previous result still sits in its output register. That section must stall in its last phase without losing the running sum or shifting its history early. This only happens when downstream back-pressure spans more than one six-clock slot while new input keeps arriving. The stimulus therefore runs long streams with random input gaps and random `m_tready` against a bit-exact integer model, plus fixed-pattern runs for latency, cadence, rounding ties and clamping.

// File: rtl/biquad_pkg.sv
package biquad_pkg;

  // Number of coefficient slots per section and the section repeat interval.
  localparam int unsigned N_SLOTS  = 5;
  localparam int unsigned SEQ_LEN  = 6;

  // Slot positions inside one section's coefficient field.
  localparam int unsigned K_B0 = 0;
  localparam int unsigned K_B1 = 1;
  localparam int unsigned K_B2 = 2;
  localparam int unsigned K_C1 = 3;
  localparam int unsigned K_C2 = 4;

  // Multiply-accumulate phase; one product per busy phase.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T0   = 3'd1,  // b0 * x[n]
    PH_T1   = 3'd2,  // b1 * x[n-1]
    PH_T2   = 3'd3,  // b2 * x[n-2]
    PH_T3   = 3'd4,  // c1 * y[n-1]
    PH_T4   = 3'd5   // c2 * y[n-2], then round, clamp and commit
  } phase_t;

endpackage

// File: rtl/biquad_seq.sv
module biquad_seq
  import biquad_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   in_valid,
  output logic   in_ready,
  output logic   out_valid,
  input  logic   out_ready,
  output logic   load,
  output logic   commit,
  output phase_t phase
);

  phase_t     phase_q;
  logic       out_valid_q;
  logic       run_q;
  logic [2:0] gap_q;     // clocks since last load, saturating; observed by assertions
  logic       out_free;

  // Named events for the datapath and the assertions.
  assign out_free  = !out_valid_q || out_ready;
  assign in_ready  = run_q && (phase_q == PH_IDLE);
  assign load      = in_ready && in_valid;
  assign commit    = (phase_q == PH_T4) && out_free;
  assign out_valid = out_valid_q;
  assign phase     = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q     <= PH_IDLE;
      out_valid_q <= 1'b0;
      run_q       <= 1'b0;
      gap_q       <= 3'd7;
    end else begin
      run_q <= 1'b1;
      unique case (phase_q)
        PH_IDLE: if (load) phase_q <= PH_T0;
        PH_T4:   if (out_free) phase_q <= PH_IDLE;
        default: phase_q <= phase_t'(3'(phase_q + 3'd1));
      endcase
      if (commit)         out_valid_q <= 1'b1;
      else if (out_ready) out_valid_q <= 1'b0;
      if (load)               gap_q <= 3'd0;
      else if (gap_q != 3'd7) gap_q <= gap_q + 3'd1;
    end
  end

  AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> gap_q >= 3'd5) else $error("start spacing"); // R4
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> gap_q >= 3'd4) else $error("result too early"); // R3
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n || !run)
    out_valid && !out_ready |=> out_valid) else $error("result dropped"); // R5

endmodule

// File: rtl/biquad_lane.sv
module biquad_lane
  import biquad_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 18
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       load,
  input  logic                       commit,
  input  phase_t                     phase,
  input  logic [N_SLOTS*COEF_W-1:0]  coef,
  input  logic signed [DATA_W-1:0]   x_in,
  output logic signed [DATA_W-1:0]   y_out
);

  localparam int unsigned FRAC   = COEF_W - 2;
  localparam int unsigned PROD_W = DATA_W + COEF_W;
  localparam int unsigned ACC_W  = PROD_W + 3;
  localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W:0] YMAX = (ACC_W+1)'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [ACC_W:0] YMIN = -YMAX - (ACC_W+1)'(1);

  // Scale the exact sum back by FRAC bits, ties toward +inf, then clamp.
  function automatic logic signed [DATA_W-1:0] scale_clamp(input logic signed [ACC_W-1:0] s);
    logic signed [ACC_W:0] r;
    r = ((ACC_W+1)'(s) + HALF) >>> FRAC;
    if (r > YMAX)      return YMAX[DATA_W-1:0];
    else if (r < YMIN) return YMIN[DATA_W-1:0];
    else               return r[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] x0_q, x1_q, x2_q, y1_q, y2_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [DATA_W-1:0] op_d;
  logic signed [COEF_W-1:0] op_c;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  sum;
  logic signed [DATA_W-1:0] y_new;

  // Operand selection follows the phase: one product per clock.
  always_comb begin
    op_d = x0_q;
    op_c = '0;
    unique case (phase)
      PH_T0:   begin op_d = x0_q; op_c = coef[K_B0*COEF_W +: COEF_W]; end
      PH_T1:   begin op_d = x1_q; op_c = coef[K_B1*COEF_W +: COEF_W]; end
      PH_T2:   begin op_d = x2_q; op_c = coef[K_B2*COEF_W +: COEF_W]; end
      PH_T3:   begin op_d = y1_q; op_c = coef[K_C1*COEF_W +: COEF_W]; end
      PH_T4:   begin op_d = y2_q; op_c = coef[K_C2*COEF_W +: COEF_W]; end
      default: begin op_d = x0_q; op_c = '0; end
    endcase
  end

  assign prod  = op_d * op_c;
  assign sum   = acc_q + ACC_W'(prod);
  assign y_new = scale_clamp(sum);
  assign y_out = y1_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      x0_q  <= '0;
      x1_q  <= '0;
      x2_q  <= '0;
      y1_q  <= '0;
      y2_q  <= '0;
      acc_q <= '0;
    end else begin
      if (load) x0_q <= x_in;
      if (phase == PH_T0)
        acc_q <= ACC_W'(prod);
      else if (phase == PH_T1 || phase == PH_T2 || phase == PH_T3)
        acc_q <= sum;
      if (commit) begin
        x1_q <= x0_q;
        x2_q <= x1_q;
        y1_q <= y_new;
        y2_q <= y1_q;
      end
    end
  end

endmodule

// File: rtl/biquad_section.sv
module biquad_section
  import biquad_pkg::*;
#(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned COEF_W   = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic [N_SLOTS*COEF_W-1:0]     coef,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [CHANNELS*DATA_W-1:0]    in_data,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [CHANNELS*DATA_W-1:0]    out_data
);

  logic   load;
  logic   commit;
  logic   clr;
  phase_t phase;

  assign clr = !run;

  biquad_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .load      (load),
    .commit    (commit),
    .phase     (phase)
  );

  // One multiplier lane per channel, all sharing the sequencer.
  for (genvar c = 0; c < CHANNELS; c++) begin : g_lane
    biquad_lane #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W)
    ) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .load   (load),
      .commit (commit),
      .phase  (phase),
      .coef   (coef),
      .x_in   (in_data[c*DATA_W +: DATA_W]),
      .y_out  (out_data[c*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/biquad_cascade.sv
module biquad_cascade
  import biquad_pkg::*;
#(
  parameter int unsigned CHANNELS = 2,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned COEF_W   = 18,
  parameter int unsigned SECTIONS = 3
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                filter_en,
  input  logic [SECTIONS*N_SLOTS*COEF_W-1:0]  coef_i,
  input  logic                                s_tvalid,
  output logic                                s_tready,
  input  logic [CHANNELS*DATA_W-1:0]          s_tdata,
  output logic                                m_tvalid,
  input  logic                                m_tready,
  output logic [CHANNELS*DATA_W-1:0]          m_tdata
);

  localparam int unsigned SEC_CW = N_SLOTS * COEF_W;
  localparam int unsigned BUS_W  = CHANNELS * DATA_W;

  // Handshake chain: index s is the input of section s.
  logic             vld [SECTIONS+1];
  logic             rdy [SECTIONS+1];
  logic [BUS_W-1:0] dat [SECTIONS+1];

  assign vld[0]         = s_tvalid;
  assign dat[0]         = s_tdata;
  assign s_tready       = rdy[0];
  assign rdy[SECTIONS]  = m_tready;
  assign m_tvalid       = vld[SECTIONS];
  assign m_tdata        = dat[SECTIONS];

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    biquad_section #(
      .CHANNELS (CHANNELS),
      .DATA_W   (DATA_W),
      .COEF_W   (COEF_W)
    ) u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (filter_en),
      .coef      (coef_i[s*SEC_CW +: SEC_CW]),
      .in_valid  (vld[s]),
      .in_ready  (rdy[s]),
      .in_data   (dat[s]),
      .out_valid (vld[s+1]),
      .out_ready (rdy[s+1]),
      .out_data  (dat[s+1])
    );
  end

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !filter_en)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata)) else $error("output changed"); // R5
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !filter_en |=> !s_tready && !m_tvalid) else $error("active while off"); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !s_tready && !m_tvalid) else $error("active in reset"); // R8

endmodule

// File: tb/tb_biquad_cascade.sv
module tb_biquad_cascade;

  localparam int S    = 2;
  localparam int CH   = 2;
  localparam int DW   = 12;
  localparam int CW   = 10;
  localparam int FRAC = CW - 2;
  localparam int W    = CH * DW;
  localparam longint YMAX = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint YMIN = -YMAX - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             filter_en = 1'b0;
  logic [S*5*CW-1:0] coef_i = '0;
  logic             s_tvalid = 1'b0;
  logic             s_tready;
  logic [W-1:0]     s_tdata = '0;
  logic             m_tvalid;
  logic             m_tready = 1'b0;
  logic [W-1:0]     m_tdata;

  biquad_cascade #(.CHANNELS(CH), .DATA_W(DW), .COEF_W(CW), .SECTIONS(S)) dut (
    .clk(clk), .rst_n(rst_n), .filter_en(filter_en), .coef_i(coef_i),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cyc = 0;

  // Reference state, indexed [section][channel].
  int     cf [S][5];
  longint hx1 [S][CH];
  longint hx2 [S][CH];
  longint hy1 [S][CH];
  longint hy2 [S][CH];

  logic [W-1:0] exp_q [$];
  string cur_tag = "R1";
  bit took, out_fire, hold_pend;
  logic [W-1:0] hold_dat, last_out;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic void model_clear();
    for (int s = 0; s < S; s++)
      for (int c = 0; c < CH; c++) begin
        hx1[s][c] = 0; hx2[s][c] = 0; hy1[s][c] = 0; hy2[s][c] = 0;
      end
  endfunction

  // Bit-exact reference: exact sum, divide by 2^FRAC rounding ties up, clamp.
  function automatic logic [W-1:0] model_step(input logic [W-1:0] din);
    logic [W-1:0] r;
    for (int c = 0; c < CH; c++) begin
      longint v = longint'($signed(din[c*DW +: DW]));
      for (int s = 0; s < S; s++) begin
        longint acc = cf[s][0]*v + cf[s][1]*hx1[s][c] + cf[s][2]*hx2[s][c]
                    + cf[s][3]*hy1[s][c] + cf[s][4]*hy2[s][c];
        longint y = (2*acc + (longint'(1) <<< FRAC)) / (longint'(1) <<< (FRAC + 1));
        if ((2*acc + (longint'(1) <<< FRAC)) < 0 &&
            ((2*acc + (longint'(1) <<< FRAC)) % (longint'(1) <<< (FRAC + 1))) != 0)
          y = y - 1;  // floor for negatives
        if (y > YMAX) y = YMAX;
        if (y < YMIN) y = YMIN;
        hx2[s][c] = hx1[s][c]; hx1[s][c] = v;
        hy2[s][c] = hy1[s][c]; hy1[s][c] = y;
        v = y;
      end
      r[c*DW +: DW] = v[DW-1:0];
    end
    return r;
  endfunction

  task automatic load_coefs(input int a0[5], input int a1[5]);
    for (int k = 0; k < 5; k++) begin
      cf[0][k] = a0[k];
      cf[1][k] = a1[k];
      coef_i[(0*5+k)*CW +: CW] = a0[k][CW-1:0];
      coef_i[(1*5+k)*CW +: CW] = a1[k][CW-1:0];
    end
  endtask

  // One clock: drive after the falling edge, then observe what the next rising edge will do.
  task automatic step(input bit vin, input logic [W-1:0] din, input bit rdy);
    @(negedge clk);
    s_tvalid = vin; s_tdata = din; m_tready = rdy;
    #1;
    cyc++;
    took = s_tvalid && s_tready;
    if (took) exp_q.push_back(model_step(din));
    if (hold_pend)
      check(m_tvalid && (m_tdata == hold_dat), "R5", longint'(m_tdata), longint'(hold_dat));
    hold_pend = m_tvalid && !m_tready;
    hold_dat  = m_tdata;
    out_fire  = m_tvalid && m_tready;
    if (out_fire) begin
      last_out = m_tdata;
      if (exp_q.size() == 0) check(0, "R5", longint'(m_tdata), -1);
      else begin
        logic [W-1:0] e = exp_q.pop_front();
        check(m_tdata == e, cur_tag, longint'(m_tdata), longint'(e));
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() > 0; i++) step(0, '0, 1);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
  endtask

  task automatic power_cycle();
    @(negedge clk); filter_en = 0; s_tvalid = 0; hold_pend = 0;
    @(negedge clk); model_clear();
    filter_en = 1;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] rnd_word();
    logic [W-1:0] r;
    for (int c = 0; c < CH; c++) r[c*DW +: DW] = DW'($urandom);
    return r;
  endfunction

  task automatic send_one(input logic [W-1:0] d);
    took = 0;
    for (int i = 0; i < 50 && !took; i++) step(1, d, 1);
  endtask

  initial begin
    int ca[5] = '{40, 60, 40, 200, -90};
    int cb[5] = '{100, -50, 30, -120, -60};
    int id[5] = '{256, 0, 0, 0, 0};
    int hf[5] = '{128, 0, 0, 0, 0};
    int big[5] = '{511, 511, 511, 0, 0};
    int n, t_prev;

    // Reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check(!s_tready, "R8", s_tready, 0);
      check(!m_tvalid, "R8", m_tvalid, 0);
    end
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check(!s_tready, "R7", s_tready, 0);

    load_coefs(ca, cb);
    model_clear();
    @(negedge clk); filter_en = 1;
    @(negedge clk);

    // Latency from acceptance to output
    cur_tag = "R3";
    send_one(W'(24'h010_123));
    n = 0; out_fire = 0;
    while (!out_fire && n < 100) begin step(0, '0, 1); n++; end
    check(n == 6*S, "R3", n, 6*S);

    // Back-to-back cadence
    cur_tag = "R4";
    t_prev = -1; n = 0;
    for (int i = 0; i < 80 && n < 6; i++) begin
      step(1, rnd_word(), 1);
      if (took) begin
        if (t_prev >= 0) check(cyc - t_prev == 6, "R4", cyc - t_prev, 6);
        t_prev = cyc; n++;
      end
    end
    drain();

    // Random traffic with random back-pressure
    cur_tag = "R1";
    n = 0;
    for (int i = 0; i < 6000 && n < 150; i++) begin
      step(($urandom % 10) < 7, rnd_word(), ($urandom % 10) < 4);
      if (took) n++;
    end
    drain();

    // Channel independence: ch0 impulse, ch1 zero
    cur_tag = "R6";
    power_cycle();
    for (int k = 0; k < 8; k++) begin
      send_one(k == 0 ? W'(12'sd900) : W'(0));
      for (int i = 0; i < 200 && exp_q.size() > 0; i++) begin
        step(0, '0, 1);
        if (out_fire) check(last_out[DW +: DW] == '0, "R6", longint'(last_out[DW +: DW]), 0);
      end
    end

    // Disabled: nothing accepted, outputs quiet, restart from zero
    cur_tag = "R7";
    @(negedge clk); filter_en = 0; hold_pend = 0;
    for (int i = 0; i < 8; i++) begin
      step(1, rnd_word(), 1);
      check(!took, "R7", took, 0);
      check(!m_tvalid, "R7", m_tvalid, 0);
    end
    s_tvalid = 0;
    model_clear();
    @(negedge clk); filter_en = 1;
    for (int k = 0; k < 5; k++) send_one(rnd_word());
    drain();

    // Identity sections: output equals input
    cur_tag = "R1";
    @(negedge clk); filter_en = 0;
    load_coefs(id, id);
    power_cycle();
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] d = rnd_word();
      send_one(d);
      drain();
      check(last_out == d, "R1", longint'(last_out), longint'(d));
    end

    // Rounding ties: half gain then identity
    cur_tag = "R2";
    @(negedge clk); filter_en = 0;
    load_coefs(hf, id);
    power_cycle();
    send_one({12'sd0, 12'sd3}); drain();
    check($signed(last_out[0 +: DW]) == 2, "R2", longint'($signed(last_out[0 +: DW])), 2);
    send_one({12'sd0, -12'sd3}); drain();
    check($signed(last_out[0 +: DW]) == -1, "R2", longint'($signed(last_out[0 +: DW])), -1);

    // Clamping at both ends
    @(negedge clk); filter_en = 0;
    load_coefs(big, id);
    power_cycle();
    for (int k = 0; k < 3; k++) begin send_one({12'sd0, 12'sd2047}); drain(); end
    check($signed(last_out[0 +: DW]) == 2047, "R2", longint'($signed(last_out[0 +: DW])), 2047);
    for (int k = 0; k < 3; k++) begin send_one({12'sd0, -12'sd2048}); drain(); end
    check($signed(last_out[0 +: DW]) == -2048, "R2", longint'($signed(last_out[0 +: DW])), -2048);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule